// File: doc/BRIEF.md
# Packet Page Allocator and Queue Manager

This block owns a small pool of packet buffer pages and tracks who holds each one. A bitmap marks every page as free or in use. Three short queues carry page numbers between the parties: one for pages waiting to be transmitted, one for pages whose transmission has finished, and one for pages holding received frames. The host drives everything through a byte-wide register port. A 3-bit command field in the command byte allocates, releases, pushes and pops pages.

The receive side asks for a page with a single request line. If a page is free and the receive queue has room, it is granted the lowest free page, and that page is pushed onto the receive queue in the same cycle. A transmit engine takes pages from the head of the pending queue. Each taken page then goes to the completion queue, or is freed at once when auto-release is on. An interrupt status byte, with a mask, drives a single interrupt line. A failed transmit allocation stays pending and is retried as soon as a page becomes free. Acknowledging the transmit-done interrupt also pops the completion queue.

Top module: `pkt_page_mgr`

## Requirements
- R1: An allocation takes the lowest-numbered free page and marks it used. An allocate-for-transmit command stores that page number in the result register (address 2). If all pages are in use, it stores 0x80 instead.
- R2: An allocate command (command code 1, in command byte bits 7:5 at address 0) clears ALLOC (status bit 3) and then sets it only on success. A failure leaves the request pending. The request is retried within two cycles of any page becoming free, and a successful retry stores the page and sets ALLOC.
- R3: Command code 0 changes nothing. Code 2 frees all pages, empties all three queues and sets the result register to 0x00. Code 7 empties the pending and completion queues. None of these three touches ALLOC.
- R4: A receive request with `rx_avail_o` high takes the lowest free page, pushes it onto the receive queue and sets RCV (status bit 0). `rx_avail_o` is low when no page is free. Reading address 4 gives the receive-queue head, or 0x80 when that queue is empty.
- R5: Code 3 pops the receive queue. Code 4 frees the receive-queue head page and then pops it. After either pop, RCV is set if entries remain and cleared if the queue is empty.
- R6: Code 6 appends the page number register (address 1) to the pending queue, which holds 4 entries; an append to a full queue is ignored. `tx_valid_o` and `tx_page_o` show the pending head, and `tx_take_i` removes it, in first-in first-out order.
- R7: A taken page is pushed onto the completion queue, whose head reads at address 3 (0x80 when empty). When auto-release (address 7, bit 0) is set, the page is freed instead.
- R8: A write to address 5 clears only those status bits that are both written as 1 and inside mask 0xD6. Writing bit 1 also pops the completion queue. TX (bit 1) is set whenever the completion queue is not empty, and TX_EMPTY (bit 2) is set whenever the pending queue is empty.
- R9: `irq_o` is high exactly when status AND mask (mask at address 6) is nonzero. After reset the status reads 0x04 and the mask reads 0x00.
- R10: If a command write and a granted receive request arrive in the same cycle, the receive allocation is done first and the command runs in the next cycle. During that next cycle `rx_avail_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| rx_req_i | input | 1 | Receive side asks for a page |
| rx_avail_o | output | 1 | A receive request would be granted this cycle |
| rx_page_o | output | 8 | Page a receive request would get |
| tx_valid_o | output | 1 | Pending transmit queue not empty |
| tx_page_o | output | 8 | Head of the pending transmit queue |
| tx_take_i | input | 1 | Transmit engine takes the head page |
| irq_o | output | 1 | Interrupt request |

## Verification
Allocation is tried in four situations: a pool that fills up one page at a time, a full pool, a release that triggers a retry, and an auto-release that triggers a retry. Together these separate lowest-first selection, the 0x80 failure code and the deferred retry. The queues are filled with distinct, repeated and overflowing page numbers and then drained, which shows the order is kept and that a fifth append is dropped. A receive request that lands in the same cycle as an allocate command is checked through the page each one ends up with. This tells the specified order apart from the reverse one. Acknowledge writes of single bits and of all ones show which status bits can be cleared and which ones come back.

// File: rtl/pkt_page_pkg.sv
package pkt_page_pkg;
  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_ALLOC   = 3'd1,
    CMD_RESET   = 3'd2,
    CMD_RX_POP  = 3'd3,
    CMD_RX_FREE = 3'd4,
    CMD_RELEASE = 3'd5,
    CMD_TX_PUSH = 3'd6,
    CMD_TX_CLR  = 3'd7
  } mmu_cmd_e;

  localparam logic [2:0] A_CMD  = 3'd0;
  localparam logic [2:0] A_PNUM = 3'd1;
  localparam logic [2:0] A_ARES = 3'd2;
  localparam logic [2:0] A_DONE = 3'd3;
  localparam logic [2:0] A_RXQ  = 3'd4;
  localparam logic [2:0] A_STAT = 3'd5;
  localparam logic [2:0] A_MASK = 3'd6;
  localparam logic [2:0] A_CTRL = 3'd7;

  localparam logic [7:0] ALLOC_FAIL = 8'h80;
  localparam logic [7:0] EMPTY_CODE = 8'h80;
  localparam logic [7:0] ACK_MASK   = 8'hD6;
endpackage

// File: rtl/page_fifo.sv
module page_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         empty_nx_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt_q, cnt_d, wr_idx;
  logic [W-1:0]  mem_q [DEPTH];
  logic [W-1:0]  mem_d [DEPTH];
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i & ~empty_o;
  assign do_push = push_i & ~full_o;
  assign wr_idx  = cnt_q - CW'(do_pop);

  always_comb begin
    cnt_d = clr_i ? '0 : cnt_q + CW'(do_push) - CW'(do_pop);
    for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
    if (do_pop)
      for (int i = 0; i < DEPTH - 1; i++) mem_d[i] = mem_q[i+1];
    if (do_push) mem_d[wr_idx] = din_i;
  end

  assign empty_nx_o = (cnt_d == '0);
  assign head_o     = mem_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  // push into a full queue is dropped
  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full_o && !pop_i && !clr_i |=> cnt_q == $past(cnt_q));

  assert_pop_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !empty_o && !push_i && !clr_i |=> cnt_q == $past(cnt_q) - CW'(1));
endmodule

// File: rtl/page_pool.sv
module page_pool #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_i,
  input  logic [N-1:0]  rel_i,
  input  logic          clr_all_i,
  output logic          free_any_o,
  output logic [PW-1:0] low_free_o
);
  logic [N-1:0] used_q, set_vec;

  always_comb begin
    low_free_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!used_q[i]) low_free_o = PW'(i);
  end

  assign free_any_o = ~&used_q;

  always_comb begin
    set_vec = '0;
    if (alloc_i) set_vec[low_free_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        used_q <= '0;
    else if (clr_all_i) used_q <= '0;
    else                used_q <= (used_q & ~rel_i) | set_vec;
  end

  assert_alloc_has_free_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> free_any_o);

  assert_alloc_marks_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i && !clr_all_i |=> used_q[$past(low_free_o)]);
endmodule

// File: rtl/pkt_page_mgr.sv
module pkt_page_mgr
  import pkt_page_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  parameter int QDEPTH    = NUM_PAGES
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [2:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       rx_req_i,
  output logic       rx_avail_o,
  output logic [7:0] rx_page_o,
  output logic       tx_valid_o,
  output logic [7:0] tx_page_o,
  input  logic       tx_take_i,
  output logic       irq_o
);
  localparam int PW = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;

  logic [7:0]  pnum_q, mask_q, ares_q, status;
  logic        auto_q, rcv_q, tx_q, txe_q, alloc_q;
  logic        cmd_pend_q;
  mmu_cmd_e    pend_cmd_q, cmd_sel;

  logic        free_any;
  logic [PW-1:0] low_free;
  logic [NUM_PAGES-1:0] rel;

  logic [PW-1:0] txq_head, doneq_head, rxq_head;
  logic txq_empty, txq_full, txq_empty_nx;
  logic doneq_empty, doneq_full, doneq_empty_nx;
  logic rxq_empty, rxq_full, rxq_empty_nx;

  logic cmd_wr, ack_wr, rx_fire, tx_fire, cmd_go;
  logic c_alloc, c_reset, c_rxpop, c_rxfree, c_release, c_txpush, c_txclr;
  logic retry, alloc_ok, doneq_pop;

  assign cmd_wr = reg_we_i && reg_addr_i == A_CMD;
  assign ack_wr = reg_we_i && reg_addr_i == A_STAT;

  // receive has priority; a colliding command is held one cycle
  assign rx_avail_o = ~cmd_pend_q & free_any & ~rxq_full;
  assign rx_fire    = rx_req_i & rx_avail_o;
  assign cmd_go     = cmd_pend_q | (cmd_wr & ~rx_fire);
  assign cmd_sel    = cmd_pend_q ? pend_cmd_q : mmu_cmd_e'(reg_wdata_i[7:5]);

  assign c_alloc   = cmd_go && cmd_sel == CMD_ALLOC;
  assign c_reset   = cmd_go && cmd_sel == CMD_RESET;
  assign c_rxpop   = cmd_go && cmd_sel == CMD_RX_POP;
  assign c_rxfree  = cmd_go && cmd_sel == CMD_RX_FREE;
  assign c_release = cmd_go && cmd_sel == CMD_RELEASE;
  assign c_txpush  = cmd_go && cmd_sel == CMD_TX_PUSH;
  assign c_txclr   = cmd_go && cmd_sel == CMD_TX_CLR;

  assign tx_fire   = tx_take_i & ~txq_empty;
  assign doneq_pop = ack_wr & reg_wdata_i[1];

  // pending allocation retries while the single allocation port is idle
  assign retry    = (ares_q == ALLOC_FAIL) && free_any && !rx_fire && !c_alloc && !c_reset;
  assign alloc_ok = (c_alloc & free_any) | retry;

  always_comb begin
    rel = '0;
    if (c_rxfree && !rxq_empty) rel[rxq_head] = 1'b1;
    if (c_release && int'(pnum_q) < NUM_PAGES) rel[pnum_q[PW-1:0]] = 1'b1;
    if (tx_fire && auto_q) rel[txq_head] = 1'b1;
  end

  page_pool #(.N(NUM_PAGES), .PW(PW)) u_pool (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .alloc_i    (rx_fire | alloc_ok),
    .rel_i      (rel),
    .clr_all_i  (c_reset),
    .free_any_o (free_any),
    .low_free_o (low_free)
  );

  page_fifo #(.DEPTH(QDEPTH), .W(PW)) u_txq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (c_reset | c_txclr),
    .push_i     (c_txpush),
    .pop_i      (tx_take_i),
    .din_i      (pnum_q[PW-1:0]),
    .head_o     (txq_head),
    .empty_o    (txq_empty),
    .full_o     (txq_full),
    .empty_nx_o (txq_empty_nx)
  );

  page_fifo #(.DEPTH(QDEPTH), .W(PW)) u_doneq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (c_reset | c_txclr),
    .push_i     (tx_fire & ~auto_q),
    .pop_i      (doneq_pop),
    .din_i      (txq_head),
    .head_o     (doneq_head),
    .empty_o    (doneq_empty),
    .full_o     (doneq_full),
    .empty_nx_o (doneq_empty_nx)
  );

  page_fifo #(.DEPTH(QDEPTH), .W(PW)) u_rxq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (c_reset),
    .push_i     (rx_fire),
    .pop_i      (c_rxpop | c_rxfree),
    .din_i      (low_free),
    .head_o     (rxq_head),
    .empty_o    (rxq_empty),
    .full_o     (rxq_full),
    .empty_nx_o (rxq_empty_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_pend_q <= 1'b0;
      pend_cmd_q <= CMD_NOP;
      pnum_q     <= '0;
      mask_q     <= '0;
      auto_q     <= 1'b0;
      ares_q     <= '0;
      rcv_q      <= 1'b0;
      tx_q       <= 1'b0;
      txe_q      <= 1'b1;
      alloc_q    <= 1'b0;
    end else begin
      cmd_pend_q <= cmd_wr & (cmd_pend_q | rx_fire);
      pend_cmd_q <= mmu_cmd_e'(reg_wdata_i[7:5]);
      if (reg_we_i && reg_addr_i == A_PNUM) pnum_q <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == A_MASK) mask_q <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == A_CTRL) auto_q <= reg_wdata_i[0];

      if (c_reset)      ares_q <= '0;
      else if (c_alloc) ares_q <= free_any ? 8'(low_free) : ALLOC_FAIL;
      else if (retry)   ares_q <= 8'(low_free);

      if (c_alloc)    alloc_q <= free_any;
      else if (retry) alloc_q <= 1'b1;

      if (rx_fire)                    rcv_q <= 1'b1;
      else if (c_rxpop || c_rxfree)   rcv_q <= ~rxq_empty_nx;

      tx_q  <= (tx_q  & ~(ack_wr & ACK_MASK[1] & reg_wdata_i[1])) | ~doneq_empty_nx;
      txe_q <= (txe_q & ~(ack_wr & ACK_MASK[2] & reg_wdata_i[2])) | txq_empty_nx;
    end
  end

  assign status = {4'b0000, alloc_q, txe_q, tx_q, rcv_q};
  assign irq_o  = |(status & mask_q);

  assign rx_page_o  = 8'(low_free);
  assign tx_valid_o = ~txq_empty;
  assign tx_page_o  = 8'(txq_head);

  always_comb begin
    unique case (reg_addr_i)
      A_CMD:  reg_rdata_o = '0;
      A_PNUM: reg_rdata_o = pnum_q;
      A_ARES: reg_rdata_o = ares_q;
      A_DONE: reg_rdata_o = doneq_empty ? EMPTY_CODE : 8'(doneq_head);
      A_RXQ:  reg_rdata_o = rxq_empty ? EMPTY_CODE : 8'(rxq_head);
      A_STAT: reg_rdata_o = status;
      A_MASK: reg_rdata_o = mask_q;
      default: reg_rdata_o = {7'b0, auto_q};
    endcase
  end

  assert_alloc_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_ok |=> status[3]);

  assert_rcv_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_fire |=> status[0]);

  assert_txq_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_txpush && txq_full && !tx_take_i |=> tx_valid_o && $stable(tx_page_o));

  assert_done_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_fire && !auto_q && doneq_full && !doneq_pop |=> $stable(doneq_head));

  assert_mask_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == A_MASK && reg_wdata_i == 8'h00 |=> !irq_o);

  assert_cmd_defer_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && rx_fire |=> cmd_pend_q && !rx_avail_o);
endmodule

// File: tb/sim_pkt_page_mgr.sv
module sim_pkt_page_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 39;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rx_req = 1'b0;
  logic       rx_avail;
  logic [7:0] rx_page;
  logic       tx_valid;
  logic [7:0] tx_page;
  logic       tx_take = 1'b0;
  logic       irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_page_mgr u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .rx_req_i    (rx_req),
    .rx_avail_o  (rx_avail),
    .rx_page_o   (rx_page),
    .tx_valid_o  (tx_valid),
    .tx_page_o   (tx_page),
    .tx_take_i   (tx_take),
    .irq_o       (irq)
  );

  // {op[1:0] 0=write 1=check 2=idle, addr[2:0], data[7:0], req[3:0]}
  localparam logic [16:0] VEC [NV] = '{
    {2'd1, 3'd5, 8'h04, 4'd9},  // R9 status after reset
    {2'd1, 3'd6, 8'h00, 4'd9},  // R9 mask after reset
    {2'd1, 3'd2, 8'h00, 4'd9},
    {2'd1, 3'd3, 8'h80, 4'd7},  // R7 empty completion queue
    {2'd1, 3'd4, 8'h80, 4'd4},  // R4 empty receive queue
    {2'd1, 3'd7, 8'h00, 4'd7},
    {2'd0, 3'd0, 8'h20, 4'd1},  // R1 lowest-first
    {2'd1, 3'd2, 8'h00, 4'd1},
    {2'd1, 3'd5, 8'h0C, 4'd2},  // R2 ALLOC set
    {2'd0, 3'd0, 8'h20, 4'd1},
    {2'd1, 3'd2, 8'h01, 4'd1},
    {2'd0, 3'd0, 8'h20, 4'd1},
    {2'd1, 3'd2, 8'h02, 4'd1},
    {2'd0, 3'd0, 8'h20, 4'd1},
    {2'd1, 3'd2, 8'h03, 4'd1},
    {2'd0, 3'd0, 8'h20, 4'd1},
    {2'd1, 3'd2, 8'h80, 4'd1},  // R1 pool full
    {2'd1, 3'd5, 8'h04, 4'd2},  // R2 ALLOC cleared on failure
    {2'd0, 3'd1, 8'h01, 4'd2},
    {2'd0, 3'd0, 8'hA0, 4'd2},  // release page 1
    {2'd2, 3'd0, 8'h00, 4'd2},
    {2'd1, 3'd2, 8'h01, 4'd2},  // R2 retry got page 1
    {2'd1, 3'd5, 8'h0C, 4'd2},
    {2'd0, 3'd1, 8'h02, 4'd6},
    {2'd0, 3'd0, 8'hC0, 4'd6},  // R6 append
    {2'd1, 3'd5, 8'h0C, 4'd8},
    {2'd0, 3'd5, 8'h04, 4'd8},  // R8 ack TX_EMPTY
    {2'd1, 3'd5, 8'h08, 4'd8},
    {2'd0, 3'd0, 8'hE0, 4'd3},  // R3 clear transmit queues
    {2'd1, 3'd5, 8'h0C, 4'd3},
    {2'd0, 3'd5, 8'hFF, 4'd8},  // R8 ack all ones
    {2'd1, 3'd5, 8'h0C, 4'd8},
    {2'd0, 3'd0, 8'h40, 4'd3},  // R3 reset pool and queues
    {2'd1, 3'd2, 8'h00, 4'd3},
    {2'd0, 3'd0, 8'h20, 4'd3},
    {2'd1, 3'd2, 8'h00, 4'd3},
    {2'd0, 3'd0, 8'h00, 4'd3},  // R3 no-op
    {2'd1, 3'd5, 8'h0C, 4'd3},
    {2'd1, 3'd2, 8'h00, 4'd3}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [7:0] msk,
                    input logic [7:0] exp);
    addr = a;
    #1;
    check(req, rdata & msk, exp);
  endtask

  task automatic take();
    @(negedge clk); tx_take = 1'b1;
    @(negedge clk); tx_take = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] exp_page);
    @(negedge clk); rx_req = 1'b1;
    #1;
    check("R4 avail", {7'b0, rx_avail}, 8'h01);
    check("R4 page", rx_page, exp_page);
    @(negedge clk); rx_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R9 irq after reset", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [2:0] va;
      logic [7:0] vd;
      logic [3:0] vt;
      {op, va, vd, vt} = VEC[i];
      if (op == 2'd0) wr(va, vd);
      else if (op == 2'd2) @(negedge clk);
      else rd($sformatf("R%0d vec %0d", vt, i), va, 8'hFF, vd);
    end

    // R6 / R7 / R8: ordering, full queue, completion queue
    wr(3'd0, 8'h40);
    wr(3'd1, 8'h00); wr(3'd0, 8'hC0);
    wr(3'd1, 8'h01); wr(3'd0, 8'hC0);
    wr(3'd1, 8'h02); wr(3'd0, 8'hC0);
    wr(3'd0, 8'hC0);
    wr(3'd0, 8'hC0);  // fifth append dropped
    #1;
    check("R6 valid", {7'b0, tx_valid}, 8'h01);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] e;
      e = (k < 2) ? 8'(k) : 8'h02;
      #1;
      check("R6 order", tx_page, e);
      take();
    end
    #1;
    check("R6 drained after four", {7'b0, tx_valid}, 8'h00);
    rd("R7 done head", 3'd3, 8'hFF, 8'h00);
    rd("R8 TX set", 3'd5, 8'h02, 8'h02);
    wr(3'd5, 8'h02);
    rd("R8 ack pops", 3'd3, 8'hFF, 8'h01);
    rd("R8 TX stays", 3'd5, 8'h02, 8'h02);
    wr(3'd5, 8'h02); wr(3'd5, 8'h02); wr(3'd5, 8'h02);
    rd("R8 done empty", 3'd3, 8'hFF, 8'h80);
    rd("R8 TX cleared", 3'd5, 8'h02, 8'h00);

    // R7 auto-release feeding an R2 retry
    wr(3'd0, 8'h40);
    wr(3'd7, 8'h01);
    rd("R7 ctrl", 3'd7, 8'hFF, 8'h01);
    for (int k = 0; k < 4; k++) wr(3'd0, 8'h20);
    rd("R1 last page", 3'd2, 8'hFF, 8'h03);
    wr(3'd1, 8'h01); wr(3'd0, 8'hC0);
    wr(3'd0, 8'h20);
    rd("R1 full", 3'd2, 8'hFF, 8'h80);
    take();
    @(negedge clk);
    rd("R2 retry after auto-release", 3'd2, 8'hFF, 8'h01);
    rd("R7 no completion entry", 3'd3, 8'hFF, 8'h80);
    wr(3'd7, 8'h00);

    // R4 / R5 receive queue
    wr(3'd0, 8'h40);
    rx_push(8'h00);
    rx_push(8'h01);
    rd("R4 rx head", 3'd4, 8'hFF, 8'h00);
    rd("R4 RCV", 3'd5, 8'h01, 8'h01);
    wr(3'd0, 8'h60);
    rd("R5 pop", 3'd4, 8'hFF, 8'h01);
    rd("R5 RCV kept", 3'd5, 8'h01, 8'h01);
    wr(3'd0, 8'h80);
    rd("R5 pop+free", 3'd4, 8'hFF, 8'h80);
    rd("R5 RCV cleared", 3'd5, 8'h01, 8'h00);
    wr(3'd0, 8'h20);
    rd("R5 head page freed", 3'd2, 8'hFF, 8'h01);
    wr(3'd0, 8'h20); wr(3'd0, 8'h20);
    #1;
    check("R4 no free page", {7'b0, rx_avail}, 8'h00);

    // R10 receive and command in the same cycle
    wr(3'd0, 8'h40);
    @(negedge clk);
    rx_req = 1'b1; we = 1'b1; addr = 3'd0; wdata = 8'h20;
    @(negedge clk);
    we = 1'b0;
    #1;
    check("R10 stall", {7'b0, rx_avail}, 8'h00);
    rd("R10 rx first", 3'd4, 8'hFF, 8'h00);
    @(negedge clk);
    rx_req = 1'b0;
    rd("R10 command next", 3'd2, 8'hFF, 8'h01);
    #1;
    check("R10 avail again", {7'b0, rx_avail}, 8'h01);

    // R9 interrupt masking: RCV=1 TX=0 TX_EMPTY=1 ALLOC=1
    #1;
    check("R9 mask zero", {7'b0, irq}, 8'h00);
    wr(3'd6, 8'h01); #1; check("R9 RCV", {7'b0, irq}, 8'h01);
    wr(3'd6, 8'h02); #1; check("R9 TX off", {7'b0, irq}, 8'h00);
    wr(3'd6, 8'h08); #1; check("R9 ALLOC", {7'b0, irq}, 8'h01);
    wr(3'd6, 8'h00); #1; check("R9 cleared", {7'b0, irq}, 8'h00);

    finish_run();
  end
endmodule